// File: doc/BRIEF.md
# Link Device Sleep Controller

This block manages the low-power states at one end of a serial video link. Software writes a one-bit sleep request. An active-low power-down pin forces the device into power-down and overrides everything else. A strap marks the end that carries the control processor. That end may never sleep, so its sleep request is forced to zero and reads back as zero. A role input selects serializer or deserializer behaviour.

A serializer goes to sleep on the clock after the request is set. A deserializer first waits in a pending state. It enters sleep when the link has been idle for a programmable number of cycles or when a timeout of a programmable number of milliseconds runs out, whichever happens first. The timeout is derived from the reference clock frequency. On entry to sleep the block emits a one-cycle pulse that clears the content-protection register bank. It does not touch any other configuration. While asleep, a rising edge on the link-activity input wakes the device and clears the request bit.

Top module: `link_sleep_ctrl`

## Requirements
- R1: With `role_deser`=0, a write of 1 to the sleep bit raises `sleep_state` after the second rising clock edge counted from the edge that takes the write.
- R2: With `role_deser`=1 and `lnk_active` held high, `sleep_state` rises after edge TERM+2 counted from the write edge, where TERM = REF_CLK_KHZ × TIMEOUT_MS is the number of cycles spent in the pending state.
- R3: With `role_deser`=1, when `lnk_active` goes low in the write cycle, `sleep_state` rises after edge IDLE_CYCLES+1, because the link is idle once the input has been low for IDLE_CYCLES consecutive edges.
- R4: With `host_side`=1, a write of 1 has no effect: `sleep_bit_rd` stays 0, and neither `sleep_state` nor `cp_reset` ever rises.
- R5: `cp_reset` is high for exactly one cycle, and that cycle is the first cycle in which `sleep_state` is high.
- R6: One edge after `pwdn_n` is sampled low, `pdown_state` is 1 and `sleep_state` is 0, whatever state the machine was in.
- R7: One edge after `pwdn_n` returns high, the machine is active. Power-down leaves the sleep bit unchanged, so if the bit is still 1 a serializer is asleep again one edge later.
- R8: While asleep, a rising edge on `lnk_active` clears `sleep_state` and `sleep_bit_rd` one edge later.
- R9: Writing 0 during the pending state returns the machine to active and clears the timeout count, so a later request waits the full TERM again.
- R10: Exactly one of the states active, pending, asleep and power-down holds at any time, so `sleep_state` and `pdown_state` are never both high.
- R11: After reset, `sleep_state`, `pdown_state`, `cp_reset` and `sleep_bit_rd` are all 0.
- R12: On the device end (`host_side`=0), `sleep_bit_rd` shows the written value one edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwdn_n | input | 1 | Active-low power-down pin |
| host_side | input | 1 | Strap: 1 = this end hosts the control processor |
| role_deser | input | 1 | 1 = deserializer, 0 = serializer |
| lnk_active | input | 1 | Serial link activity indication |
| sleep_wr_en | input | 1 | Write strobe for the sleep bit |
| sleep_wr_data | input | 1 | Value written to the sleep bit |
| sleep_bit_rd | output | 1 | Readback of the sleep bit |
| sleep_state | output | 1 | Device is asleep |
| pdown_state | output | 1 | Device is in power-down |
| cp_reset | output | 1 | One-cycle reset pulse for content-protection registers |

## Verification
All results are registered, so every latency is counted in rising edges from the edge that takes the stimulus. A serializer sleeps after edge 2. An idle-entered deserializer sleeps after edge IDLE_CYCLES+1, and a timeout-entered one after edge TERM+2. Wake and power-down both take effect one edge after the stimulus. The bench drives and samples on falling edges and counts edges from the write until `sleep_state` rises, then compares that count with the expected one. This way an off-by-one in the idle counter, the timeout counter or the state register appears as a wrong count rather than passing unnoticed.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
    typedef enum logic [3:0] {
        ST_ACTIVE  = 4'b0001,
        ST_PENDING = 4'b0010,
        ST_ASLEEP  = 4'b0100,
        ST_PDOWN   = 4'b1000
    } lsc_state_e;
endpackage

// File: rtl/lsc_link_monitor.sv
module lsc_link_monitor #(
    parameter int unsigned IDLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lnk_active,
    output logic link_idle,
    output logic act_rise
);
    localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] IDLE_LIM = CW'(IDLE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] idle_cnt;
        logic          act_prev;
    } mon_t;

    mon_t mon_d, mon_q;

    always_comb begin
        mon_d          = mon_q;
        mon_d.act_prev = lnk_active;
        if (lnk_active)
            mon_d.idle_cnt = '0;
        else if (mon_q.idle_cnt != IDLE_LIM)
            mon_d.idle_cnt = mon_q.idle_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mon_q <= '0;
        else        mon_q <= mon_d;
    end

    assign link_idle = (mon_q.idle_cnt == IDLE_LIM);
    assign act_rise  = lnk_active & ~mon_q.act_prev;

    // R3: the idle count saturates and never passes the limit
    a_r3_idle_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        mon_q.idle_cnt <= IDLE_LIM);

    // R3: activity restarts the idle count
    a_r3_idle_restart: assert property (@(posedge clk) disable iff (!rst_n)
        lnk_active |=> !link_idle);
endmodule

// File: rtl/lsc_sleep_timer.sv
module lsc_sleep_timer #(
    parameter int unsigned REF_CLK_KHZ = 50000,
    parameter int unsigned TIMEOUT_MS  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned TERM = REF_CLK_KHZ * TIMEOUT_MS;
    localparam int unsigned TW   = $clog2(TERM + 1);
    localparam logic [TW-1:0] LAST = TW'(TERM - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!run)
            tmr_d.cnt = '0;
        else if (tmr_q.cnt != LAST)
            tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign expired = run && (tmr_q.cnt == LAST);

    // R2: the count stays within the terminal value
    a_r2_timer_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);

    // R9: stopping the timer returns it to zero
    a_r9_timer_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> tmr_q.cnt == '0);
endmodule

// File: rtl/lsc_sleep_fsm.sv
module lsc_sleep_fsm
    import lsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwdn_n,
    input  logic       sleep_req,
    input  logic       role_deser,
    input  logic       link_idle,
    input  logic       timer_expired,
    input  logic       wake_evt,
    output lsc_state_e state,
    output logic       cp_pulse,
    output logic       timer_run
);
    typedef struct packed {
        lsc_state_e st;
        logic       cp;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        case (fsm_q.st)
            ST_ACTIVE:
                if (sleep_req)
                    fsm_d.st = role_deser ? ST_PENDING : ST_ASLEEP;
            ST_PENDING:
                if (!sleep_req)
                    fsm_d.st = ST_ACTIVE;
                else if (link_idle || timer_expired)
                    fsm_d.st = ST_ASLEEP;
            ST_ASLEEP:
                if (wake_evt || !sleep_req)
                    fsm_d.st = ST_ACTIVE;
            ST_PDOWN:
                fsm_d.st = ST_ACTIVE;
            default:
                fsm_d.st = ST_ACTIVE;
        endcase
        if (!pwdn_n)
            fsm_d.st = ST_PDOWN;
        fsm_d.cp = (fsm_d.st == ST_ASLEEP) && (fsm_q.st != ST_ASLEEP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.st <= ST_ACTIVE;
            fsm_q.cp <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state     = fsm_q.st;
    assign cp_pulse  = fsm_q.cp;
    assign timer_run = (fsm_q.st == ST_PENDING);

    // R10: exactly one state bit set
    a_r10_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fsm_q.st) == 1);

    // R5: pulse accompanies entry into sleep
    a_r5_cp_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.st == ST_ASLEEP) |-> fsm_q.cp);

    // R5: pulse lasts one cycle
    a_r5_cp_single: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.cp |=> !fsm_q.cp);

    // R8: a wake event leaves the asleep state
    a_r8_wake_exits: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> fsm_q.st != ST_ASLEEP);

    // R1: the pending state only serves the deserializer role
    a_r1_ser_no_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.st == ST_ACTIVE && !role_deser) |=> fsm_q.st != ST_PENDING);
endmodule

// File: rtl/link_sleep_ctrl.sv
module link_sleep_ctrl
    import lsc_pkg::*;
#(
    parameter int unsigned REF_CLK_KHZ = 50000,
    parameter int unsigned TIMEOUT_MS  = 8,
    parameter int unsigned IDLE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwdn_n,
    input  logic host_side,
    input  logic role_deser,
    input  logic lnk_active,
    input  logic sleep_wr_en,
    input  logic sleep_wr_data,
    output logic sleep_bit_rd,
    output logic sleep_state,
    output logic pdown_state,
    output logic cp_reset
);
    typedef struct packed {
        logic sleep_bit;
    } ctl_t;

    ctl_t       ctl_d, ctl_q;
    lsc_state_e cur_state;
    logic       link_idle, act_rise, timer_run, timer_expired, wake_evt, cp_pulse;

    lsc_link_monitor #(.IDLE_CYCLES(IDLE_CYCLES)) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .lnk_active(lnk_active),
        .link_idle (link_idle),
        .act_rise  (act_rise)
    );

    lsc_sleep_timer #(.REF_CLK_KHZ(REF_CLK_KHZ), .TIMEOUT_MS(TIMEOUT_MS)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (timer_run),
        .expired(timer_expired)
    );

    assign wake_evt = act_rise && pwdn_n && (cur_state == ST_ASLEEP);

    lsc_sleep_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwdn_n       (pwdn_n),
        .sleep_req    (ctl_q.sleep_bit),
        .role_deser   (role_deser),
        .link_idle    (link_idle),
        .timer_expired(timer_expired),
        .wake_evt     (wake_evt),
        .state        (cur_state),
        .cp_pulse     (cp_pulse),
        .timer_run    (timer_run)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (host_side)
            ctl_d.sleep_bit = 1'b0;
        else if (wake_evt)
            ctl_d.sleep_bit = 1'b0;
        else if (sleep_wr_en)
            ctl_d.sleep_bit = sleep_wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign sleep_bit_rd = ctl_q.sleep_bit;
    assign sleep_state  = (cur_state == ST_ASLEEP);
    assign pdown_state  = (cur_state == ST_PDOWN);
    assign cp_reset     = cp_pulse;

    // R4: a host-side device never sleeps
    a_r4_host_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (host_side && $past(host_side) && $past(host_side, 2)) |-> !sleep_state);

    // R6: power-down overrides sleep
    a_r6_pdown_priority: assert property (@(posedge clk) disable iff (!rst_n)
        !pwdn_n |=> (pdown_state && !sleep_state));

    // R8: wake clears the request bit
    a_r8_wake_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
        wake_evt |=> !sleep_bit_rd);
endmodule

// File: tb/test_link_sleep_ctrl.sv
module test_link_sleep_ctrl;
    localparam int unsigned KHZ  = 5;
    localparam int unsigned MS   = 8;
    localparam int unsigned IDLE = 8;
    localparam int          TERM = KHZ * MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwdn_n = 1'b1;
    logic host_side = 1'b0;
    logic role_deser = 1'b0;
    logic lnk_active = 1'b1;
    logic sleep_wr_en = 1'b0;
    logic sleep_wr_data = 1'b0;
    logic sleep_bit_rd, sleep_state, pdown_state, cp_reset;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    link_sleep_ctrl #(.REF_CLK_KHZ(KHZ), .TIMEOUT_MS(MS), .IDLE_CYCLES(IDLE)) i_link_sleep_ctrl (
        .clk(clk), .rst_n(rst_n), .pwdn_n(pwdn_n), .host_side(host_side),
        .role_deser(role_deser), .lnk_active(lnk_active),
        .sleep_wr_en(sleep_wr_en), .sleep_wr_data(sleep_wr_data),
        .sleep_bit_rd(sleep_bit_rd), .sleep_state(sleep_state),
        .pdown_state(pdown_state), .cp_reset(cp_reset)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // drive a write, return after the edge that takes it
    task automatic write_bit(input logic v);
        sleep_wr_en = 1'b1;
        sleep_wr_data = v;
        @(negedge clk);
        sleep_wr_en = 1'b0;
    endtask

    // edges from the write edge until sleep_state is seen high
    task automatic edges_to_sleep(output int n, output int cp_at_entry);
        n = 1;
        while (!sleep_state && n < 500) begin
            @(negedge clk);
            n++;
        end
        cp_at_entry = int'(cp_reset);
    endtask

    task automatic wake_up();
        lnk_active = 1'b0;
        step(1);
        lnk_active = 1'b1;
        step(1);
    endtask

    task automatic t_reset();
        check("R11 sleep_state", int'(sleep_state), 0);
        check("R11 pdown_state", int'(pdown_state), 0);
        check("R11 cp_reset", int'(cp_reset), 0);
        check("R11 sleep_bit_rd", int'(sleep_bit_rd), 0);
    endtask

    task automatic t_ser();
        int n, cp;
        role_deser = 1'b0;
        write_bit(1'b1);
        check("R12 readback", int'(sleep_bit_rd), 1);
        edges_to_sleep(n, cp);
        check("R1 edges", n, 2);
        check("R5 pulse at entry", cp, 1);
        step(1);
        check("R5 pulse one cycle", int'(cp_reset), 0);
        check("R1 still asleep", int'(sleep_state), 1);
        wake_up();
        check("R8 sleep cleared", int'(sleep_state), 0);
        check("R8 bit cleared", int'(sleep_bit_rd), 0);
    endtask

    task automatic t_deser_timeout();
        int n, cp;
        role_deser = 1'b1;
        lnk_active = 1'b1;
        write_bit(1'b1);
        edges_to_sleep(n, cp);
        check("R2 edges", n, TERM + 2);
        check("R5 pulse at entry", cp, 1);
        wake_up();
        check("R8 wake deser", int'(sleep_state), 0);
    endtask

    task automatic t_deser_idle();
        int n, cp;
        role_deser = 1'b1;
        lnk_active = 1'b0;
        write_bit(1'b1);
        edges_to_sleep(n, cp);
        check("R3 edges", n, IDLE + 1);
        step(3);
        lnk_active = 1'b1;
        step(1);
        check("R8 rise wakes", int'(sleep_state), 0);
        check("R8 rise clears bit", int'(sleep_bit_rd), 0);
    endtask

    task automatic t_abort();
        int n, cp;
        role_deser = 1'b1;
        lnk_active = 1'b1;
        write_bit(1'b1);
        step(20);
        write_bit(1'b0);
        step(4);
        check("R9 aborted", int'(sleep_state), 0);
        write_bit(1'b1);
        edges_to_sleep(n, cp);
        check("R9 full wait again", n, TERM + 2);
        wake_up();
    endtask

    task automatic t_host();
        int seen_sleep = 0, seen_cp = 0;
        host_side = 1'b1;
        role_deser = 1'b0;
        step(2);
        write_bit(1'b1);
        check("R4 readback zero", int'(sleep_bit_rd), 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sleep_state) seen_sleep = 1;
            if (cp_reset) seen_cp = 1;
        end
        check("R4 never asleep", seen_sleep, 0);
        check("R4 no pulse", seen_cp, 0);
        pwdn_n = 1'b0;
        step(1);
        check("R6 host powers down", int'(pdown_state), 1);
        pwdn_n = 1'b1;
        step(1);
        host_side = 1'b0;
        step(2);
    endtask

    task automatic t_pdown();
        int n, cp;
        role_deser = 1'b0;
        lnk_active = 1'b1;
        write_bit(1'b1);
        edges_to_sleep(n, cp);
        pwdn_n = 1'b0;
        step(1);
        check("R6 pdown_state", int'(pdown_state), 1);
        check("R6 sleep forced low", int'(sleep_state), 0);
        check("R10 not both", int'(sleep_state && pdown_state), 0);
        step(5);
        check("R7 bit retained", int'(sleep_bit_rd), 1);
        pwdn_n = 1'b1;
        step(1);
        check("R7 active after release", int'(pdown_state | sleep_state), 0);
        step(1);
        check("R7 sleeps again", int'(sleep_state), 1);
        wake_up();
    endtask

    initial begin
        #4000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_ser();
        t_deser_timeout();
        t_deser_idle();
        t_abort();
        t_host();
        t_pdown();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule